// File: doc/BRIEF.md
# Masked Vector Execution Unit

This block executes integer vector instructions on a single lane and handles one element per clock. It holds a set of vector registers, a vector length value and a per-element mask. An instruction is presented on a valid/ready port and selects one of five operations: vector plus vector, vector minus vector, vector plus scalar, vector times scalar, or a not-equal compare of a vector against a scalar. The compare writes the mask. Each arithmetic result is written only where the mask bit is set and the element index lies below the active length. A one-cycle completion pulse marks the write of the last element.

Two instructions can be in flight at once. The second one is accepted while the first is still running, and it trails the first by at least one element. It may therefore consume element i of a register, or mask bit i, as soon as the first instruction has produced it. This is how dependent operations chain without waiting for a whole vector. A combinational observation port reads any register element. The mask is visible as a bit vector.

Top module: `vexu_top`

## Requirements
- R1: After reset, every register element is zero, all mask bits are one, the length is the maximum, `ins_ready` is high and `done` is low.
- R2: Operation codes on `ins_op` are: 0 = `va + vb`, 1 = `va - vb`, 2 = `va + scalar`, 3 = low ELEM_W bits of `va * scalar`. Each result is taken modulo 2^ELEM_W and written to `vd` element by element.
- R3: Code 4 sets mask bit i to 1 exactly when element i of `va` differs from the scalar, for i below the length. Mask bits at or above the length are unchanged, and no register element is written.
- R4: An arithmetic instruction writes element i only when mask bit i is 1. Destination elements whose mask bit is 0 keep their previous value.
- R5: Only elements with index below the length latched at acceptance are written. Elements above it keep their value.
- R6: A length write above MAX_VL stores MAX_VL. Any other value is stored as given.
- R7: With a length of 0, an accepted instruction writes nothing and `done` pulses in the first cycle after the accepting edge.
- R8: For a length L ≥ 1, `done` is a one-cycle pulse that becomes visible L cycles after the accepting clock edge.
- R9: An instruction accepted on the edge after another one chains behind it. It reads the values the first one produced, and its `done` follows the first one's `done` by exactly one cycle.
- R10: `ins_ready` is low while two instructions are in flight and high otherwise.
- R11: A cycle with `mask_clr` high sets every mask bit to 1 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Unit can accept an instruction |
| ins_op | input | 3 | Operation code (see R2, R3) |
| ins_vd | input | log2(NUM_VREG) | Destination register |
| ins_va | input | log2(NUM_VREG) | First source register |
| ins_vb | input | log2(NUM_VREG) | Second source register (vector-vector forms) |
| ins_scalar | input | ELEM_W | Scalar operand |
| len_we | input | 1 | Write the length register |
| len_wdata | input | LEN_IN_W | New length value |
| mask_clr | input | 1 | Restore the mask to all ones |
| done | output | 1 | Instruction completion pulse |
| mask_bits | output | MAX_VL | Current mask |
| obs_reg | input | log2(NUM_VREG) | Observation register select |
| obs_idx | input | log2(MAX_VL) | Observation element select |
| obs_data | output | ELEM_W | Selected element value |

## Verification
The bench builds varied data purely through the instruction port. It repeats scalar adds under shrinking lengths, so a unit that ignored the length would produce a flat vector instead of a ramp. It sweeps lengths 0, 9 and 200 along with in-range values. A missing clamp would leave elements stale or produce a wrong completion time, and a missing zero-length shortcut would hang or write. Compares are run with a short length and followed by masked subtracts and adds, which exposes a mask that leaks above the length or a write that ignores a cleared bit. Back-to-back dependent pairs, including a compare that feeds a masked add, would show stale operands or a late second completion if chaining read too early or waited for the whole vector.

// File: rtl/vexu_pkg.sv
package vexu_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int unsigned VOP_W = 3;

   typedef enum logic [VOP_W-1:0] {
      VOP_ADD_VV = 3'd0,
      VOP_SUB_VV = 3'd1,
      VOP_ADD_VS = 3'd2,
      VOP_MUL_VS = 3'd3,
      VOP_CMP_NE = 3'd4
   } vop_e;
endpackage

// File: rtl/vexu_vrf.sv
// Vector register storage: one flop word per element, NWR write ports,
// NRD combinational read ports.
module vexu_vrf #(
   parameter int unsigned NUM_VREG = 8,
   parameter int unsigned MAX_VL   = 64,
   parameter int unsigned ELEM_W   = 64,
   parameter int unsigned NRD      = 5,
   parameter int unsigned NWR      = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [$clog2(NUM_VREG)-1:0] rd_reg  [NRD],
   input  logic [$clog2(MAX_VL)-1:0]   rd_idx  [NRD],
   output logic [ELEM_W-1:0]           rd_data [NRD],
   input  logic [NWR-1:0]              wr_en,
   input  logic [$clog2(NUM_VREG)-1:0] wr_reg  [NWR],
   input  logic [$clog2(MAX_VL)-1:0]   wr_idx  [NWR],
   input  logic [ELEM_W-1:0]           wr_data [NWR]
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int unsigned REGW  = $clog2(NUM_VREG);
   localparam int unsigned IDXW  = $clog2(MAX_VL);
   localparam int unsigned NCELL = NUM_VREG * MAX_VL;

   logic [NCELL-1:0][ELEM_W-1:0] cells;

   for (genvar r = 0; r < NUM_VREG; r++) begin : g_reg
      for (genvar e = 0; e < MAX_VL; e++) begin : g_elem
         logic [ELEM_W-1:0] q;
         logic              hit;
         logic [ELEM_W-1:0] nxt;

         always_comb begin
            hit = 1'b0;
            nxt = q;
            for (int w = 0; w < NWR; w++) begin
               if (wr_en[w] && wr_reg[w] == REGW'(r) && wr_idx[w] == IDXW'(e)) begin
                  hit = 1'b1;
                  nxt = wr_data[w];
               end
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= nxt;
         end

         assign cells[r*MAX_VL+e] = q;
      end
   end

   for (genvar k = 0; k < NRD; k++) begin : g_rd
      assign rd_data[k] = cells[{rd_reg[k], rd_idx[k]}];
   end
endmodule

// File: rtl/vexu_vmask.sv
// Per-element mask register with NWR bit-set ports and a clear to all ones.
module vexu_vmask #(
   parameter int unsigned MAX_VL = 64,
   parameter int unsigned NWR    = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr,
   input  logic [NWR-1:0]            set_en,
   input  logic [$clog2(MAX_VL)-1:0] set_idx [NWR],
   input  logic [NWR-1:0]            set_val,
   output logic [MAX_VL-1:0]         bits
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int unsigned IDXW = $clog2(MAX_VL);

   for (genvar b = 0; b < MAX_VL; b++) begin : g_bit
      logic q;
      logic hit;
      logic nxt;

      always_comb begin
         hit = 1'b0;
         nxt = q;
         for (int w = 0; w < NWR; w++) begin
            if (set_en[w] && set_idx[w] == IDXW'(b)) begin
               hit = 1'b1;
               nxt = set_val[w];
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n)   q <= 1'b1;
         else if (clr) q <= 1'b1;
         else if (hit) q <= nxt;
      end

      assign bits[b] = q;
   end
endmodule

// File: rtl/vexu_alu.sv
// Element operation: produces a register write or a mask write for one element.
module vexu_alu
   import vexu_pkg::*;
#(
   parameter int unsigned ELEM_W = 64
) (
   input  logic [VOP_W-1:0]  op,
   input  logic [ELEM_W-1:0] a,
   input  logic [ELEM_W-1:0] b,
   input  logic [ELEM_W-1:0] scalar,
   input  logic              mask_bit,
   output logic              vr_we,
   output logic [ELEM_W-1:0] vr_data,
   output logic              mk_we,
   output logic              mk_val
);
   timeunit 1ns;
   timeprecision 100ps;

   always_comb begin
      vr_we   = 1'b0;
      vr_data = '0;
      mk_we   = 1'b0;
      mk_val  = 1'b0;
      case (vop_e'(op))
         VOP_ADD_VV: begin vr_we = mask_bit; vr_data = a + b;      end
         VOP_SUB_VV: begin vr_we = mask_bit; vr_data = a - b;      end
         VOP_ADD_VS: begin vr_we = mask_bit; vr_data = a + scalar; end
         VOP_MUL_VS: begin vr_we = mask_bit; vr_data = a * scalar; end
         VOP_CMP_NE: begin mk_we = 1'b1;     mk_val  = (a != scalar); end
         default: ;
      endcase
   end
endmodule

// File: rtl/vexu_seq.sv
// One instruction slot: holds the decoded instruction and walks its element index.
module vexu_seq #(
   parameter int unsigned NUM_VREG = 8,
   parameter int unsigned MAX_VL   = 64,
   parameter int unsigned ELEM_W   = 64,
   parameter int unsigned OP_W     = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [OP_W-1:0]              in_op,
   input  logic [$clog2(NUM_VREG)-1:0]  in_vd,
   input  logic [$clog2(NUM_VREG)-1:0]  in_va,
   input  logic [$clog2(NUM_VREG)-1:0]  in_vb,
   input  logic [ELEM_W-1:0]            in_scalar,
   input  logic [$clog2(MAX_VL+1)-1:0]  in_vl,
   input  logic                         go,
   output logic                         busy,
   output logic [$clog2(MAX_VL+1)-1:0]  idx,
   output logic                         last,
   output logic                         step,
   output logic                         retire,
   output logic [OP_W-1:0]              op,
   output logic [$clog2(NUM_VREG)-1:0]  vd,
   output logic [$clog2(NUM_VREG)-1:0]  va,
   output logic [$clog2(NUM_VREG)-1:0]  vb,
   output logic [ELEM_W-1:0]            scalar
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int unsigned VLW = $clog2(MAX_VL+1);

   logic [VLW-1:0] vl_q;

   assign last   = busy && ((vl_q == '0) || (idx == vl_q - VLW'(1)));
   assign step   = busy && go && (vl_q != '0);
   assign retire = busy && go && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         idx    <= '0;
         vl_q   <= '0;
         op     <= '0;
         vd     <= '0;
         va     <= '0;
         vb     <= '0;
         scalar <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         idx    <= '0;
         vl_q   <= in_vl;
         op     <= in_op;
         vd     <= in_vd;
         va     <= in_va;
         vb     <= in_vb;
         scalar <= in_scalar;
      end else if (busy && go) begin
         if (last) busy <= 1'b0;
         else      idx  <= idx + VLW'(1);
      end
   end
endmodule

// File: rtl/vexu_top.sv
// Single-lane masked vector unit with two chained instruction slots.
module vexu_top
   import vexu_pkg::*;
#(
   parameter int unsigned NUM_VREG = 8,
   parameter int unsigned MAX_VL   = 64,
   parameter int unsigned ELEM_W   = 64,
   parameter int unsigned LEN_IN_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ins_valid,
   output logic                        ins_ready,
   input  logic [2:0]                  ins_op,
   input  logic [$clog2(NUM_VREG)-1:0] ins_vd,
   input  logic [$clog2(NUM_VREG)-1:0] ins_va,
   input  logic [$clog2(NUM_VREG)-1:0] ins_vb,
   input  logic [ELEM_W-1:0]           ins_scalar,
   input  logic                        len_we,
   input  logic [LEN_IN_W-1:0]         len_wdata,
   input  logic                        mask_clr,
   output logic                        done,
   output logic [MAX_VL-1:0]           mask_bits,
   input  logic [$clog2(NUM_VREG)-1:0] obs_reg,
   input  logic [$clog2(MAX_VL)-1:0]   obs_idx,
   output logic [ELEM_W-1:0]           obs_data
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int unsigned REGW  = $clog2(NUM_VREG);
   localparam int unsigned IDXW  = $clog2(MAX_VL);
   localparam int unsigned VLW   = $clog2(MAX_VL+1);
   localparam int unsigned NSLOT = 2;
   localparam int unsigned NRD   = 2*NSLOT + 1;

   if (NUM_VREG < 2 || (NUM_VREG & (NUM_VREG-1)) != 0) begin : g_bad_nreg
      $error("NUM_VREG must be a power of two of at least 2");
   end
   if (MAX_VL < 2 || (MAX_VL & (MAX_VL-1)) != 0) begin : g_bad_vl
      $error("MAX_VL must be a power of two of at least 2");
   end
   if (ELEM_W < 2) begin : g_bad_w
      $error("ELEM_W must be at least 2");
   end
   if (LEN_IN_W < VLW) begin : g_bad_lenw
      $error("LEN_IN_W too narrow to carry MAX_VL");
   end

   // slot state
   logic [NSLOT-1:0] s_busy, s_start, s_go, s_last, s_step, s_retire;
   logic [VLW-1:0]   s_idx    [NSLOT];
   logic [VOP_W-1:0] s_op     [NSLOT];
   logic [REGW-1:0]  s_vd     [NSLOT];
   logic [REGW-1:0]  s_va     [NSLOT];
   logic [REGW-1:0]  s_vb     [NSLOT];
   logic [ELEM_W-1:0] s_scalar [NSLOT];

   // register file ports
   logic [REGW-1:0]   rd_reg  [NRD];
   logic [IDXW-1:0]   rd_idx  [NRD];
   logic [ELEM_W-1:0] rd_data [NRD];
   logic [NSLOT-1:0]  wr_en;
   logic [REGW-1:0]   wr_reg  [NSLOT];
   logic [IDXW-1:0]   wr_idx  [NSLOT];
   logic [ELEM_W-1:0] wr_data [NSLOT];

   // mask ports
   logic [NSLOT-1:0]  mk_en;
   logic [IDXW-1:0]   mk_idx [NSLOT];
   logic [NSLOT-1:0]  mk_val;

   logic [VLW-1:0]    vl_q;
   logic              elder_q;
   logic              done_q;
   logic [NSLOT-1:0]  busy_nx;
   logic              accept;
   logic              tgt;
   logic              cmp_step;

   // issue
   assign ins_ready  = ~&s_busy;
   assign accept     = ins_valid & ins_ready;
   assign tgt        = s_busy[0];
   assign s_start[0] = accept & ~tgt;
   assign s_start[1] = accept &  tgt;
   assign busy_nx    = s_start | (s_busy & ~s_retire);
   assign cmp_step   = |mk_en;
   assign done       = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         elder_q <= 1'b0;
         done_q  <= 1'b0;
         vl_q    <= VLW'(MAX_VL);
      end else begin
         elder_q <= busy_nx[elder_q] ? elder_q : ~elder_q;
         done_q  <= |s_retire;
         if (len_we) begin
            if (len_wdata > LEN_IN_W'(MAX_VL)) vl_q <= VLW'(MAX_VL);
            else                               vl_q <= len_wdata[VLW-1:0];
         end
      end
   end

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      localparam int unsigned O = NSLOT - 1 - s;
      logic              alu_we;
      logic [ELEM_W-1:0] alu_data;
      logic              alu_mk_we;
      logic              alu_mk_val;

      // The younger slot stays strictly behind the elder and never retires
      // in the same cycle, so writes never collide and done stays one per cycle.
      assign s_go[s] = !s_busy[O] || (elder_q == 1'(s)) ||
                       ((s_idx[O] > s_idx[s]) && !(s_last[s] && s_last[O]));

      vexu_seq #(
         .NUM_VREG (NUM_VREG),
         .MAX_VL   (MAX_VL),
         .ELEM_W   (ELEM_W),
         .OP_W     (VOP_W)
      ) i_seq (
         .clk       (clk),
         .rst_n     (rst_n),
         .start     (s_start[s]),
         .in_op     (ins_op),
         .in_vd     (ins_vd),
         .in_va     (ins_va),
         .in_vb     (ins_vb),
         .in_scalar (ins_scalar),
         .in_vl     (vl_q),
         .go        (s_go[s]),
         .busy      (s_busy[s]),
         .idx       (s_idx[s]),
         .last      (s_last[s]),
         .step      (s_step[s]),
         .retire    (s_retire[s]),
         .op        (s_op[s]),
         .vd        (s_vd[s]),
         .va        (s_va[s]),
         .vb        (s_vb[s]),
         .scalar    (s_scalar[s])
      );

      assign rd_reg[2*s]   = s_va[s];
      assign rd_idx[2*s]   = s_idx[s][IDXW-1:0];
      assign rd_reg[2*s+1] = s_vb[s];
      assign rd_idx[2*s+1] = s_idx[s][IDXW-1:0];

      vexu_alu #(.ELEM_W(ELEM_W)) i_alu (
         .op       (s_op[s]),
         .a        (rd_data[2*s]),
         .b        (rd_data[2*s+1]),
         .scalar   (s_scalar[s]),
         .mask_bit (mask_bits[s_idx[s][IDXW-1:0]]),
         .vr_we    (alu_we),
         .vr_data  (alu_data),
         .mk_we    (alu_mk_we),
         .mk_val   (alu_mk_val)
      );

      assign wr_en[s]   = s_step[s] & alu_we;
      assign wr_reg[s]  = s_vd[s];
      assign wr_idx[s]  = s_idx[s][IDXW-1:0];
      assign wr_data[s] = alu_data;
      assign mk_en[s]   = s_step[s] & alu_mk_we;
      assign mk_idx[s]  = s_idx[s][IDXW-1:0];
      assign mk_val[s]  = alu_mk_val;
   end

   assign rd_reg[NRD-1] = obs_reg;
   assign rd_idx[NRD-1] = obs_idx;
   assign obs_data      = rd_data[NRD-1];

   vexu_vrf #(
      .NUM_VREG (NUM_VREG),
      .MAX_VL   (MAX_VL),
      .ELEM_W   (ELEM_W),
      .NRD      (NRD),
      .NWR      (NSLOT)
   ) i_vrf (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_reg  (rd_reg),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .wr_en   (wr_en),
      .wr_reg  (wr_reg),
      .wr_idx  (wr_idx),
      .wr_data (wr_data)
   );

   vexu_vmask #(
      .MAX_VL (MAX_VL),
      .NWR    (NSLOT)
   ) i_vmask (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (mask_clr),
      .set_en  (mk_en),
      .set_idx (mk_idx),
      .set_val (mk_val),
      .bits    (mask_bits)
   );
endmodule

// File: rtl/vexu_chk.sv
module vexu_chk #(
   parameter int unsigned MAX_VL   = 64,
   parameter int unsigned LEN_IN_W = 8
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          ins_valid,
   input logic                          ins_ready,
   input logic                          done,
   input logic                          mask_clr,
   input logic [MAX_VL-1:0]             mask_bits,
   input logic                          len_we,
   input logic [LEN_IN_W-1:0]           len_wdata,
   input logic [$clog2(MAX_VL+1)-1:0]   vl_q,
   input logic                          cmp_step
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int unsigned VLW = $clog2(MAX_VL+1);

   logic [2:0] live;
   logic [2:0] live_now;

   always_ff @(posedge clk) begin
      if (!rst_n) live <= '0;
      else        live <= live + {2'b0, ins_valid & ins_ready} - {2'b0, done};
   end
   assign live_now = live - {2'b0, done};

   AST_DONE_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (live != 3'd0)); // R8
   AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (live_now == 3'd2) |-> !ins_ready); // R10
   AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ins_ready); // R10
   AST_LIVE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      live_now <= 3'd2); // R10
   AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      mask_clr |=> (&mask_bits)); // R11
   AST_MASK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mask_bits) |-> $past(mask_clr || cmp_step)); // R3
   AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      len_we |=> (vl_q == (($past(len_wdata) > LEN_IN_W'(MAX_VL)) ?
                            VLW'(MAX_VL) : VLW'($past(len_wdata))))); // R6
endmodule

bind vexu_top vexu_chk #(
   .MAX_VL   (MAX_VL),
   .LEN_IN_W (LEN_IN_W)
) i_vexu_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ins_valid (ins_valid),
   .ins_ready (ins_ready),
   .done      (done),
   .mask_clr  (mask_clr),
   .mask_bits (mask_bits),
   .len_we    (len_we),
   .len_wdata (len_wdata),
   .vl_q      (vl_q),
   .cmp_step  (cmp_step)
);

// File: tb/test_vexu_top.sv
module test_vexu_top;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int NV = 4;
   localparam int VL = 8;
   localparam int EW = 16;
   localparam int LW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ins_valid = 1'b0;
   logic          ins_ready;
   logic [2:0]    ins_op = '0;
   logic [1:0]    ins_vd = '0, ins_va = '0, ins_vb = '0;
   logic [EW-1:0] ins_scalar = '0;
   logic          len_we = 1'b0;
   logic [LW-1:0] len_wdata = '0;
   logic          mask_clr = 1'b0;
   logic          done;
   logic [VL-1:0] mask_bits;
   logic [1:0]    obs_reg = '0;
   logic [2:0]    obs_idx = '0;
   logic [EW-1:0] obs_data;

   int checks = 0;
   int failures = 0;

   logic [EW-1:0] m [NV][VL];
   logic [VL-1:0] mm;
   int            mvl;

   always #2.5 clk = ~clk;

   vexu_top #(.NUM_VREG(NV), .MAX_VL(VL), .ELEM_W(EW), .LEN_IN_W(LW)) i_vexu_top (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
      .ins_op(ins_op), .ins_vd(ins_vd), .ins_va(ins_va), .ins_vb(ins_vb),
      .ins_scalar(ins_scalar), .len_we(len_we), .len_wdata(len_wdata),
      .mask_clr(mask_clr), .done(done), .mask_bits(mask_bits),
      .obs_reg(obs_reg), .obs_idx(obs_idx), .obs_data(obs_data)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic model(input logic [2:0] op, input int vd, input int va, input int vb,
                        input logic [EW-1:0] s);
      for (int i = 0; i < mvl; i++) begin
         logic [EW-1:0] a, b;
         a = m[va][i];
         b = m[vb][i];
         case (op)
            3'd0: if (mm[i]) m[vd][i] = a + b;
            3'd1: if (mm[i]) m[vd][i] = a - b;
            3'd2: if (mm[i]) m[vd][i] = a + s;
            3'd3: if (mm[i]) m[vd][i] = EW'(a * s);
            3'd4: mm[i] = (a != s);
            default: ;
         endcase
      end
   endtask

   task automatic compare_all(input string req);
      for (int r = 0; r < NV; r++) begin
         for (int e = 0; e < VL; e++) begin
            @(posedge clk);
            obs_reg = 2'(r);
            obs_idx = 3'(e);
            @(negedge clk);
            check(req, 64'(obs_data), 64'(m[r][e]));
         end
      end
      check(req, 64'(mask_bits), 64'(mm));
   endtask

   task automatic set_len(input int v);
      @(negedge clk);
      len_we = 1'b1;
      len_wdata = LW'(v);
      @(negedge clk);
      len_we = 1'b0;
      mvl = (v > VL) ? VL : v;
   endtask

   task automatic drive(input logic [2:0] op, input int vd, input int va, input int vb,
                        input logic [EW-1:0] s);
      ins_valid  = 1'b1;
      ins_op     = op;
      ins_vd     = 2'(vd);
      ins_va     = 2'(va);
      ins_vb     = 2'(vb);
      ins_scalar = s;
   endtask

   task automatic run(input logic [2:0] op, input int vd, input int va, input int vb,
                      input logic [EW-1:0] s, input string req);
      int lat;
      @(negedge clk);
      drive(op, vd, va, vb, s);
      @(posedge clk);
      @(negedge clk);
      ins_valid = 1'b0;
      lat = 0;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      if (mvl == 0) check("R7 latency", 64'(lat), 64'd1);
      else          check("R8 latency", 64'(lat), 64'(mvl));
      @(negedge clk);
      check("R8 pulse", 64'(done), 64'd0);
      model(op, vd, va, vb, s);
      compare_all(req);
   endtask

   task automatic chain(input logic [2:0] opa, input int vda, input int vaa, input int vba,
                        input logic [EW-1:0] sa,
                        input logic [2:0] opb, input int vdb, input int vab, input int vbb,
                        input logic [EW-1:0] sb);
      int ta, tb;
      ta = -1;
      tb = -1;
      @(negedge clk);
      drive(opa, vda, vaa, vba, sa);
      @(posedge clk);
      @(negedge clk);
      check("R10 ready one busy", 64'(ins_ready), 64'd1);
      drive(opb, vdb, vab, vbb, sb);
      @(posedge clk);
      @(negedge clk);
      ins_valid = 1'b0;
      check("R10 ready two busy", 64'(ins_ready), 64'd0);
      for (int t = 1; t < 30; t++) begin
         if (done) begin
            if (ta < 0) ta = t;
            else if (tb < 0) tb = t;
         end
         @(negedge clk);
      end
      check("R9 first done", 64'(ta), 64'(mvl));
      check("R9 second done", 64'(tb), 64'(mvl + 1));
      model(opa, vda, vaa, vba, sa);
      model(opb, vdb, vab, vbb, sb);
      compare_all("R9 chained data");
   endtask

   initial begin
      logic [EW-1:0] svals [6];
      int            lens  [7];
      svals = '{16'h0000, 16'h0001, 16'h0003, 16'hFFFF, 16'h8001, 16'h7FFF};
      lens  = '{0, 1, 3, 7, 8, 9, 200};
      for (int r = 0; r < NV; r++)
         for (int e = 0; e < VL; e++)
            m[r][e] = '0;
      mm  = '1;
      mvl = VL;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready", 64'(ins_ready), 64'd1);
      check("R1 done", 64'(done), 64'd0);
      check("R1 mask", 64'(mask_bits), 64'hFF);
      compare_all("R1 regs");

      // default length is the maximum: all 8 elements get +1
      run(3'd2, 1, 1, 0, 16'd1, "R1 length");
      // ramp v1[i] = 8 - i using shrinking lengths
      for (int k = 1; k < VL; k++) begin
         set_len(k);
         run(3'd2, 1, 1, 0, 16'd1, "R5 ramp");
      end
      set_len(VL);

      // arithmetic sweep over scalars
      foreach (svals[j]) begin
         run(3'd2, 2, 1, 0, svals[j], "R2 add_vs");
         run(3'd3, 3, 2, 0, svals[j], "R2 mul_vs");
         run(3'd0, 0, 2, 3, svals[j], "R2 add_vv");
         run(3'd1, 0, 0, 1, svals[j], "R2 sub_vv");
      end

      // length sweep incl. zero and clamp
      foreach (lens[j]) begin
         set_len(lens[j]);
         if (lens[j] == 0)     run(3'd2, 2, 1, 0, 16'h5, "R7 no write");
         else if (lens[j] > VL) run(3'd2, 2, 1, 0, 16'h5, "R6 clamp");
         else                  run(3'd2, 2, 1, 0, 16'h5, "R5 length");
      end

      // compare and masked arithmetic
      set_len(VL);
      run(3'd4, 0, 1, 0, 16'd3, "R3 compare");
      run(3'd1, 3, 3, 1, 16'd0, "R4 masked sub");
      run(3'd4, 0, 1, 0, 16'd8, "R3 compare");
      run(3'd2, 2, 2, 0, 16'd11, "R4 masked add");
      set_len(5);
      run(3'd4, 0, 1, 0, 16'd7, "R3 short compare");
      run(3'd0, 2, 2, 1, 16'd0, "R4 masked short add");
      @(negedge clk);
      mask_clr = 1'b1;
      @(negedge clk);
      mask_clr = 1'b0;
      mm = '1;
      check("R11 mask clear", 64'(mask_bits), 64'hFF);

      // chaining
      set_len(VL);
      chain(3'd3, 2, 1, 0, 16'd3, 3'd0, 3, 2, 1, 16'd0);
      chain(3'd4, 0, 1, 0, 16'd4, 3'd2, 0, 0, 0, 16'd9);
      set_len(6);
      chain(3'd0, 2, 1, 3, 16'd0, 3'd1, 3, 2, 0, 16'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL R8 watchdog: actual hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule